// File: doc/BRIEF.md
# Aligned Circular DMA Address Generator

This block computes the host-memory offsets at which received frame data is written into a circular DMA buffer. A frame is opened with a start strobe that carries the frame's byte length. Each accepted 16-bit word is then written at the current offset, and the offset moves forward by two bytes. When the last word of a frame has been accepted, the offset jumps to the next 32-bit boundary, so the next frame always begins double-word aligned. This can leave a gap of one to three unused bytes after a frame.

The offset wraps modulo the selected buffer size, either 16 KB or 64 KB. A host-readable start-of-frame register keeps the offset of the most recently completed frame. A one-cycle done pulse goes to a downstream commitment tracker, and that tracker can stall word acceptance. A DMA clear input abandons any open frame and returns the ring to offset zero.

Top module: `dma_ring_addr`

## Requirements
- R1: While a frame is open, each cycle with `word_vld_i` high and `stall_i` low accepts a word. `wr_en_o` is high in exactly those cycles. `wr_addr_o` gives the byte offset of the accepted word: the frame's start offset for the first word, then two more for each following word. With no frame open, `wr_en_o` stays low.
- R2: A frame of L bytes takes ceil(L/2) words. The next frame starts at the previous start plus L rounded up to a multiple of 4, so every start offset is 32-bit aligned.
- R3: All offsets wrap modulo the selected buffer size, including wraps in the middle of a frame. `buf_sel_i`=0 selects 16384 bytes and `buf_sel_i`=1 selects 65536 bytes.
- R4: `sof_ofs_o` changes only when a frame completes. It then takes that frame's start offset, in the same cycle as `frame_done_o`. It stays unchanged while a frame is open.
- R5: `frame_done_o` is a single-cycle pulse in the cycle after the frame's last word is accepted.
- R6: While `stall_i` is high, no word is accepted, `wr_en_o` is low, and `wr_addr_o` and the remaining word count hold.
- R7: `dma_clr_i` abandons any open frame without a done pulse. From the next cycle, `wr_addr_o` and `sof_ofs_o` read zero.
- R8: A `sof_i` strobe that arrives while a frame is open is ignored. The open frame keeps its original length.
- R9: After reset, `wr_addr_o`, `sof_ofs_o` and `frame_done_o` are zero, and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_clr_i | input | 1 | Return ring to offset zero, abandon frame |
| buf_sel_i | input | 1 | Buffer size: 0 = 16 KB, 1 = 64 KB |
| stall_i | input | 1 | Hold from commitment tracker |
| sof_i | input | 1 | Frame start strobe |
| frame_len_i | input | LEN_W | Frame length in bytes, sampled with `sof_i` |
| word_vld_i | input | 1 | A data word is offered |
| wr_en_o | output | 1 | Word accepted this cycle |
| wr_addr_o | output | OFS_W | Byte offset of the current word |
| sof_ofs_o | output | OFS_W | Start offset of the last completed frame |
| frame_done_o | output | 1 | Frame completed (one-cycle pulse) |

## Verification
The main function is tried with frame lengths of every residue modulo 4, plus a one-byte frame. Together these show whether the alignment jump lands on the correct next boundary for gaps of 0, 1, 2 and 3 bytes. A frame that crosses the 16 KB boundary checks the wrap in the middle of a frame. The same offsets are then run in 64 KB mode to show that the buffer-size select changes the wrap point. Stalls, a second start strobe inside an open frame, and a clear in the middle of a frame show, respectively, that the word count freezes, that the original length is kept, and that the frame is dropped without a done pulse.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  typedef enum logic {
    BUF_16K = 1'b0,
    BUF_64K = 1'b1
  } buf_sel_e;

  // byte offset to the next 32-bit boundary after the word at ofs
  function automatic logic [15:0] next_dword16(input logic [15:0] ofs);
    logic [15:0] t;
    t = ofs + 16'd4;
    return {t[15:2], 2'b00};
  endfunction
endpackage

// File: rtl/frame_word_ctr.sv
module frame_word_ctr #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sof_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             word_vld_i,
  input  logic             stall_i,
  output logic             start_o,
  output logic             accept_o,
  output logic             last_o
);
  logic             busy_q;
  logic [LEN_W-1:0] left_q;
  logic [LEN_W:0]   len_rnd;

  assign len_rnd  = {1'b0, len_i} + {{LEN_W{1'b0}}, 1'b1};
  assign start_o  = sof_i & ~busy_q;
  assign accept_o = busy_q & word_vld_i & ~stall_i;
  assign last_o   = accept_o & (left_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start_o) begin
      busy_q <= (len_i != '0);
      left_q <= len_rnd[LEN_W:1];
    end else if (accept_o) begin
      busy_q <= ~last_o;
      left_q <= left_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/ring_ofs_ctr.sv
module ring_ofs_ctr #(
  parameter int unsigned OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic [OFS_W-1:0] mask_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] ofs_q, ofs_inc, ofs_aln;

  assign ofs_inc = ofs_q + OFS_W'(2);
  assign ofs_aln = (ofs_q + OFS_W'(4)) & {{(OFS_W-2){1'b1}}, 2'b00};
  assign ofs_o   = ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ofs_q <= '0;
    else if (clr_i)  ofs_q <= '0;
    else if (step_i) ofs_q <= (last_i ? ofs_aln : ofs_inc) & mask_i;
  end
endmodule

// File: rtl/sof_track.sv
module sof_track #(
  parameter int unsigned OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             last_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [OFS_W-1:0] sof_ofs_o,
  output logic             done_o
);
  logic [OFS_W-1:0] start_q, sof_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      sof_q   <= '0;
      done_q  <= 1'b0;
    end else if (clr_i) begin
      start_q <= '0;
      sof_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (start_i) start_q <= ofs_i;
      if (last_i)  sof_q   <= start_q;
      done_q <= last_i;
    end
  end

  assign sof_ofs_o = sof_q;
  assign done_o    = done_q;
endmodule

// File: rtl/dma_ring_addr.sv
module dma_ring_addr #(
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned SMALL_W = 14,
  parameter int unsigned LEN_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_clr_i,
  input  logic             buf_sel_i,
  input  logic             stall_i,
  input  logic             sof_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic             word_vld_i,
  output logic             wr_en_o,
  output logic [OFS_W-1:0] wr_addr_o,
  output logic [OFS_W-1:0] sof_ofs_o,
  output logic             frame_done_o
);
  import dma_ring_pkg::*;

  localparam logic [OFS_W-1:0] MASK_LG = '1;
  localparam logic [OFS_W-1:0] MASK_SM = MASK_LG >> (OFS_W - SMALL_W);

  logic             start, accept, last;
  logic [OFS_W-1:0] mask;

  assign mask = (buf_sel_e'(buf_sel_i) == BUF_64K) ? MASK_LG : MASK_SM;

  frame_word_ctr #(.LEN_W(LEN_W)) i_wctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (dma_clr_i),
    .sof_i      (sof_i),
    .len_i      (frame_len_i),
    .word_vld_i (word_vld_i),
    .stall_i    (stall_i),
    .start_o    (start),
    .accept_o   (accept),
    .last_o     (last)
  );

  ring_ofs_ctr #(.OFS_W(OFS_W)) i_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (dma_clr_i),
    .step_i (accept),
    .last_i (last),
    .mask_i (mask),
    .ofs_o  (wr_addr_o)
  );

  sof_track #(.OFS_W(OFS_W)) i_sof (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (dma_clr_i),
    .start_i   (start),
    .last_i    (last),
    .ofs_i     (wr_addr_o),
    .sof_ofs_o (sof_ofs_o),
    .done_o    (frame_done_o)
  );

  assign wr_en_o = accept;
endmodule

// File: rtl/dma_ring_addr_chk.sv
module dma_ring_addr_chk #(
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned SMALL_W = 14,
  parameter int unsigned LEN_W   = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dma_clr_i,
  input logic             buf_sel_i,
  input logic             stall_i,
  input logic             sof_i,
  input logic [LEN_W-1:0] frame_len_i,
  input logic             word_vld_i,
  input logic             wr_en_o,
  input logic [OFS_W-1:0] wr_addr_o,
  input logic [OFS_W-1:0] sof_ofs_o,
  input logic             frame_done_o
);
  localparam logic [OFS_W-1:0] MASK_LG = '1;
  localparam logic [OFS_W-1:0] MASK_SM = MASK_LG >> (OFS_W - SMALL_W);
  logic [OFS_W-1:0] mask_c;
  assign mask_c = buf_sel_i ? MASK_LG : MASK_SM;

  AST_WORD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !dma_clr_i) |=> (frame_done_o ||
      wr_addr_o == ((($past(wr_addr_o) + OFS_W'(2))) & $past(mask_c)))); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_o && !dma_clr_i) |=> $stable(wr_addr_o)); // R6
  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (wr_addr_o[1:0] == 2'b00 && sof_ofs_o[1:0] == 2'b00)); // R2
  AST_WRAP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !buf_sel_i && !dma_clr_i) |=> (wr_addr_o >> SMALL_W) == '0); // R3
  AST_SOF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_clr_i |=> (frame_done_o || $stable(sof_ofs_o))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o); // R5
  AST_STALL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !wr_en_o); // R6
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_clr_i |=> (wr_addr_o == '0 && sof_ofs_o == '0 && !frame_done_o)); // R7
endmodule

bind dma_ring_addr dma_ring_addr_chk #(
  .OFS_W(OFS_W), .SMALL_W(SMALL_W), .LEN_W(LEN_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dma_clr_i(dma_clr_i), .buf_sel_i(buf_sel_i),
  .stall_i(stall_i), .sof_i(sof_i), .frame_len_i(frame_len_i),
  .word_vld_i(word_vld_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .sof_ofs_o(sof_ofs_o), .frame_done_o(frame_done_o)
);

// File: tb/test_dma_ring_addr.sv
`timescale 1ns/1ps
module test_dma_ring_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_clr = 1'b0, buf_sel = 1'b0, stall = 1'b0, sof = 1'b0, word_vld = 1'b0;
  logic [15:0] frame_len = '0;
  logic        wr_en, frame_done;
  logic [15:0] wr_addr, sof_ofs;
  int          n_run = 0, n_fail = 0;
  int          cur_sof = 0;

  always #2 clk = ~clk;

  dma_ring_addr i_dma_ring_addr (
    .clk_i(clk), .rst_ni(rst_n), .dma_clr_i(dma_clr), .buf_sel_i(buf_sel),
    .stall_i(stall), .sof_i(sof), .frame_len_i(frame_len), .word_vld_i(word_vld),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .sof_ofs_o(sof_ofs), .frame_done_o(frame_done)
  );

  // sel, len, expected start, expected next start
  localparam int VEC [5][4] = '{
    '{0, 60, 0, 60}, '{0, 61, 60, 124}, '{0, 62, 124, 188},
    '{0, 63, 188, 252}, '{0, 1, 252, 256}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int sel, input int len, input int st, input int nx,
                           input string req);
    int words = (len + 1) / 2;
    int size  = sel ? 65536 : 16384;
    int bad_k = -1, bad_a = 0, bad_e = 0;
    @(negedge clk); buf_sel = sel[0]; sof = 1'b1; frame_len = 16'(len);
    @(negedge clk); sof = 1'b0; word_vld = 1'b1;
    for (int k = 0; k < words; k++) begin
      #1;
      if (bad_k < 0 && (wr_addr !== 16'((st + 2 * k) % size) || wr_en !== 1'b1)) begin
        bad_k = k; bad_a = int'(wr_addr); bad_e = (st + 2 * k) % size;
      end
      if (k == 0) chk(sof_ofs == 16'(cur_sof), "R4", "sof_ofs before done", int'(sof_ofs), cur_sof);
      if (k == words - 1 && words > 1)
        chk(frame_done == 1'b0, "R5", "no early done", int'(frame_done), 0);
      @(negedge clk);
    end
    word_vld = 1'b0;
    chk(bad_k < 0, req, "word address sequence (R1)", bad_a, bad_e);
    chk(frame_done == 1'b1, "R5", "done after last word", int'(frame_done), 1);
    chk(sof_ofs == 16'(st), "R4", "sof_ofs at done", int'(sof_ofs), st);
    cur_sof = st;
    @(negedge clk);
    chk(frame_done == 1'b0, "R5", "done one cycle", int'(frame_done), 0);
    chk(wr_addr == 16'(nx), "R2", "next aligned start", int'(wr_addr), nx);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    #9 rst_n = 1'b1;
    // R9 reset state, R1 no write with no frame open
    @(negedge clk); word_vld = 1'b1; #1;
    chk(wr_addr == 0, "R9", "wr_addr reset", int'(wr_addr), 0);
    chk(sof_ofs == 0, "R9", "sof_ofs reset", int'(sof_ofs), 0);
    chk(frame_done == 0, "R9", "frame_done reset", int'(frame_done), 0);
    chk(wr_en == 0, "R1", "wr_en idle", int'(wr_en), 0);
    word_vld = 1'b0;

    // R2 all length residues
    for (int i = 0; i < 5; i++) run_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], "R2");
    // R3 wrap mid-frame in 16 KB, then 64 KB
    run_frame(0, 16380, 256, 252, "R3");
    run_frame(1, 65000, 252, 65252, "R3");
    run_frame(1, 400, 65252, 116, "R3");

    // R6 stall: len 8 at 116
    @(negedge clk); buf_sel = 1'b0; sof = 1'b1; frame_len = 16'd8;
    @(negedge clk); sof = 1'b0; word_vld = 1'b1;
    @(negedge clk); stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(wr_en == 0 && wr_addr == 16'd118, "R6", "stall holds", int'(wr_addr), 118);
      @(negedge clk);
    end
    stall = 1'b0;
    cnt = 0;
    while (frame_done !== 1'b1 && cnt < 20) begin @(negedge clk); cnt++; end
    word_vld = 1'b0;
    chk(cnt == 3, "R6", "words left after stall", cnt, 3);
    @(negedge clk);
    chk(wr_addr == 16'd124, "R6", "next start after stall", int'(wr_addr), 124);

    // R8 second sof during open frame: len 20 at 124
    @(negedge clk); sof = 1'b1; frame_len = 16'd20;
    @(negedge clk); sof = 1'b0; word_vld = 1'b1;
    @(negedge clk);
    @(negedge clk); sof = 1'b1; frame_len = 16'd200;
    @(negedge clk); sof = 1'b0;
    cnt = 3;
    while (frame_done !== 1'b1 && cnt < 200) begin @(negedge clk); cnt++; end
    word_vld = 1'b0;
    chk(cnt == 10, "R8", "word count kept", cnt, 10);
    chk(sof_ofs == 16'd124, "R8", "sof_ofs", int'(sof_ofs), 124);
    @(negedge clk);
    chk(wr_addr == 16'd144, "R8", "next start", int'(wr_addr), 144);

    // R7 clear mid-frame
    @(negedge clk); sof = 1'b1; frame_len = 16'd40;
    @(negedge clk); sof = 1'b0; word_vld = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    word_vld = 1'b0; dma_clr = 1'b1;
    @(negedge clk); dma_clr = 1'b0; #1;
    chk(wr_addr == 0, "R7", "wr_addr cleared", int'(wr_addr), 0);
    chk(sof_ofs == 0, "R7", "sof_ofs cleared", int'(sof_ofs), 0);
    word_vld = 1'b1; cnt = 0;
    for (int k = 0; k < 30; k++) begin
      #1; if (wr_en || frame_done) cnt++;
      @(negedge clk);
    end
    word_vld = 1'b0;
    chk(cnt == 0, "R7", "frame abandoned", cnt, 0);
    cur_sof = 0;
    run_frame(0, 6, 0, 8, "R7");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule